// File: doc/BRIEF.md
# Transmit Data Pair Buffer

This block holds the two transmit data bytes that software loads for a message and hands them, one at a time, to a shared receive/transmit shift register. Bytes leave in pairs. The serializer first copies the low holding register into the shift register, and then the high holding register once the first byte has gone out. A buffer-empty flag follows the high register. It sets when that register is copied out, and software uses it as the signal to load the next pair.

The empty flag clears only when software writes the high register. As a result, a message with an odd number of data bytes, or with none, needs a dummy write to the high register to clear the flag. The flag also sets when the serializer reports that a valid message has been fully sent. A transmit interrupt is the flag gated by an enable input. The flag has no write path from software and is only observed at its output.

Top module: `can_tx_pair_buf`

## Requirements
- R1: A high-copy pulse (`ld_hi_i`) loads the high register into `shift_o` and sets `empty_o` on the next clock, unless the high register is written in the same cycle (see R7).
- R2: A CPU write to the high register (`wr_hi_i`) stores `wdata_i` and leaves `empty_o` at 0 after the clock, whatever else happens in that cycle.
- R3: While `rst_n` is low, `empty_o` is 1, `shift_o` is 0 and both holding registers are 0.
- R4: A message-complete pulse (`msg_done_i`) sets `empty_o` on the next clock, unless the high register is written in the same cycle.
- R5: `tx_irq_o` is 1 exactly when `empty_o` is 1 and `tx_ie_i` is 1. It responds without delay to a change of `tx_ie_i`, and it stays asserted until the high register is written.
- R6: A low-copy pulse (`ld_lo_i`) loads the low register into `shift_o` on the next clock and does not change `empty_o`.
- R7: When the high register is written in the same cycle as a high copy, `shift_o` takes the old high byte, `empty_o` ends at 0, and the new byte is held for the following high copy.
- R8: `empty_o` keeps its value when no high write, high copy or message-complete occurs. Writes to the low register never change `empty_o`.
- R9: If low-copy and high-copy pulses arrive together, the low copy is performed and the high copy is dropped. `empty_o` is then left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdata_i | input | DATA_W | CPU write data |
| wr_lo_i | input | 1 | CPU write strobe, low (first) holding register |
| wr_hi_i | input | 1 | CPU write strobe, high (second) holding register |
| ld_lo_i | input | 1 | Serializer request: copy low register into shift register |
| ld_hi_i | input | 1 | Serializer request: copy high register into shift register |
| msg_done_i | input | 1 | Valid message fully transmitted |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| shift_o | output | DATA_W | Shift register contents |
| empty_o | output | 1 | Transmit buffer empty flag |
| tx_irq_o | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with the default `DATA_W` of 8. This makes it possible to use distinct byte patterns, so a byte that went to the wrong holding register, or a stale byte, shows up directly in `shift_o`. Under that width, the bench walks through full pairs, an odd-length message closed by a dummy write, a write that collides with a high copy, and two copy pulses arriving together. It also toggles the interrupt enable while the flag is held.

// File: rtl/can_tx_pair_buf.sv
module can_tx_pair_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic              msg_done_i,
  input  logic              tx_ie_i,
  output logic [DATA_W-1:0] shift_o,
  output logic              empty_o,
  output logic              tx_irq_o
);

  logic [DATA_W-1:0] lo_q, hi_q, sh_q;
  logic              emp_q;
  logic              hi_copy;

  assign hi_copy = ld_hi_i && !ld_lo_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo_i) lo_q <= wdata_i;
      if (wr_hi_i) hi_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sh_q <= '0;
    else if (ld_lo_i)  sh_q <= lo_q;
    else if (hi_copy)  sh_q <= hi_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       emp_q <= 1'b1;
    else if (wr_hi_i)                 emp_q <= 1'b0;
    else if (hi_copy || msg_done_i)   emp_q <= 1'b1;
  end

  assign shift_o  = sh_q;
  assign empty_o  = emp_q;
  assign tx_irq_o = emp_q & tx_ie_i;

endmodule

module can_tx_pair_buf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_lo_i,
  input logic              wr_hi_i,
  input logic              ld_lo_i,
  input logic              ld_hi_i,
  input logic              msg_done_i,
  input logic              tx_ie_i,
  input logic [DATA_W-1:0] lo_q,
  input logic [DATA_W-1:0] hi_q,
  input logic [DATA_W-1:0] shift_o,
  input logic              empty_o,
  input logic              tx_irq_o
);

  AST_HI_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_i |=> !empty_o); // R2

  AST_HI_COPY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi_i && !ld_lo_i && !wr_hi_i) |=> (empty_o && shift_o == $past(hi_q))); // R1

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done_i && !wr_hi_i) |=> empty_o); // R4

  AST_LO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo_i |=> (shift_o == $past(lo_q) && empty_o == $past(empty_o))); // R6

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi_i && !msg_done_i && !(ld_hi_i && !ld_lo_i)) |=> $stable(empty_o)); // R8

  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_i && tx_ie_i) |=> (!tx_irq_o || !tx_ie_i)); // R5

endmodule

bind can_tx_pair_buf can_tx_pair_buf_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i),
  .ld_lo_i(ld_lo_i), .ld_hi_i(ld_hi_i), .msg_done_i(msg_done_i),
  .tx_ie_i(tx_ie_i), .lo_q(lo_q), .hi_q(hi_q), .shift_o(shift_o),
  .empty_o(empty_o), .tx_irq_o(tx_irq_o)
);

// File: tb/can_tx_pair_buf_tb.sv
module can_tx_pair_buf_tb_top;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] wdata = '0;
  logic wr_lo = 0, wr_hi = 0, ld_lo = 0, ld_hi = 0, done = 0, ie = 0;
  logic [W-1:0] shift;
  logic empty, irq;

  always #5 clk = ~clk;

  can_tx_pair_buf #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wdata_i(wdata), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .ld_lo_i(ld_lo), .ld_hi_i(ld_hi), .msg_done_i(done), .tx_ie_i(ie),
    .shift_o(shift), .empty_o(empty), .tx_irq_o(irq)
  );

  typedef struct {
    string  tag;
    logic [W-1:0] sh;
    logic   em;
    logic   iq;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic [W-1:0] m_lo = '0, m_hi = '0, m_sh = '0;
  logic m_em = 1'b1;
  bit finished = 0;

  task automatic chk(string tag, logic [W-1:0] a_sh, logic a_em, logic a_iq, exp_t e);
    checks++;
    if (a_sh !== e.sh || a_em !== e.em || a_iq !== e.iq) begin
      fails++;
      $display("FAIL %s: shift=%h empty=%b irq=%b expected shift=%h empty=%b irq=%b",
               tag, a_sh, a_em, a_iq, e.sh, e.em, e.iq);
    end
  endtask

  task automatic step(string tag, logic wl, logic wh, logic [W-1:0] d,
                      logic ll, logic lh, logic dn, logic en);
    exp_t e;
    @(negedge clk);
    wr_lo = wl; wr_hi = wh; wdata = d; ld_lo = ll; ld_hi = lh; done = dn; ie = en;
    if (ll)      m_sh = m_lo;
    else if (lh) m_sh = m_hi;
    if (wh)            m_em = 1'b0;
    else if ((lh && !ll) || dn) m_em = 1'b1;
    if (wl) m_lo = d;
    if (wh) m_hi = d;
    e.tag = tag; e.sh = m_sh; e.em = m_em; e.iq = m_em & en;
    q.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, shift, empty, irq, e);
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    ie = 1;
    #1;
    r.tag = "R3 reset"; r.sh = '0; r.em = 1'b1; r.iq = 1'b1;
    chk(r.tag, shift, empty, irq, r);
    @(negedge clk); rst_n = 1;

    step("R8 low write keeps flag", 1, 0, 8'hAA, 0, 0, 0, 1);
    step("R2 high write clears",    0, 1, 8'hBB, 0, 0, 0, 1);
    step("R6 low copy",             0, 0, 8'h00, 1, 0, 0, 1);
    step("R1 high copy sets flag",  0, 0, 8'h00, 0, 1, 0, 1);
    step("R5 irq with enable",      0, 0, 8'h00, 0, 0, 0, 1);
    step("R5 irq masked",           0, 0, 8'h00, 0, 0, 0, 0);
    step("R5 irq re-enabled held",  0, 0, 8'h00, 0, 0, 0, 1);
    step("R7 load low 11",          1, 0, 8'h11, 0, 0, 0, 1);
    step("R7 load high 22",         0, 1, 8'h22, 0, 0, 0, 1);
    step("R7 low copy",             0, 0, 8'h00, 1, 0, 0, 1);
    step("R7 write during copy",    0, 1, 8'h33, 0, 1, 0, 1);
    step("R8 idle holds clear",     0, 0, 8'h00, 0, 0, 0, 1);
    step("R7 held byte copied",     0, 0, 8'h00, 0, 1, 0, 1);
    step("R2 odd message low",      1, 0, 8'h44, 0, 0, 0, 1);
    step("R2 odd message dummy",    0, 1, 8'h00, 0, 0, 0, 1);
    step("R6 odd low copy",         0, 0, 8'h00, 1, 0, 0, 1);
    step("R4 message done",         0, 0, 8'h00, 0, 0, 1, 1);
    step("R2 zero-byte dummy",      0, 1, 8'h5A, 0, 0, 0, 1);
    step("R4 done with write",      0, 1, 8'h66, 0, 0, 1, 1);
    step("R9 both copies",          1, 0, 8'h77, 1, 1, 0, 1);
    step("R9 both copies again",    0, 0, 8'h00, 1, 1, 0, 1);
    step("R8 idle",                 0, 0, 8'h00, 0, 0, 0, 0);
    step("R1 final high copy",      0, 0, 8'h00, 0, 1, 0, 1);
    @(negedge clk);
    ld_hi = 0; ie = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule